// File: doc/BRIEF.md
# Watchdog with Selectable Time Base

This block is a system watchdog reached through an index/data configuration port. Four watchdog registers become visible only while a device-select register holds the general-purpose I/O device number. Software sets a 16-bit reload value, picks whether one count unit is one second or one minute, and chooses what happens on expiry. The options are a keyboard-reset pulse, a power-good-drop pulse and a routed interrupt line.

A one-per-second tick input drives the time base. In minute mode an internal prescaler divides that tick by sixty. Two external activity inputs can restart the count: an infrared-receiver activity strobe and a game-port access strobe. Each has its own enable. A restart from these inputs takes effect after a fixed latency, as a real receiver path would. A zero reload value keeps the timer stopped.

Top module: `swd_watchdog`

## Requirements
- R1: After reset, every register reads 0x00, the device-select register holds 0, the timer is stopped and `kbrst_o`, `pgdrop_o` and `irq_o` are all low.
- R2: Index 0x07 is the device-select register and can always be accessed. Indexes 0x71 (control), 0x72 (config), 0x73 (count low) and 0x74 (count high) respond only while device-select equals `GPIO_LDN` (default 7). Otherwise, writes to them are ignored and reads return 0x00. Unknown indexes read 0x00.
- R3: A write to either count byte replaces that byte of the 16-bit programmed value and restarts the counter from the whole new value, in the cycle after the write.
- R4: While the programmed value is zero the timer is stopped and never expires, whatever the tick input does.
- R5: With config bit 7 set, the count drops by one on each `tick_sec` pulse. With it clear, the count drops by one on every sixtieth pulse, counted from the last restart.
- R6: When the count reaches zero, control bit 0 (status) becomes 1. A control write with bit 0 = 0 clears it. If expiry and that write fall in the same cycle, the status ends up set.
- R7: On expiry, `kbrst_o` gives one pulse of `PULSE_CYC` cycles if config bit 6 is set, and `pgdrop_o` gives one such pulse if config bit 4 is set. Neither fires again until the counter has been restarted and expires again.
- R8: A pulse on `ir_act` with control bit 7 set, or on `gp_act` with control bit 4 set, restarts the counter from the programmed value exactly `RELOAD_LAT` cycles later. With the enable clear, the pulse is ignored.
- R9: A count-byte write or a delayed restart that lands in the same cycle as a unit tick wins: the count takes the programmed value and is not decremented.
- R10: While status is set and config bits 3:0 hold a non-zero value n, `irq_o[n]` is high and every other bit of `irq_o` is low. With n = 0, `irq_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 8 | Register index on the configuration port |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the indexed register (combinational) |
| tick_sec | input | 1 | One-cycle pulse once per second |
| ir_act | input | 1 | Infrared-receiver activity strobe |
| gp_act | input | 1 | Game-port access strobe |
| kbrst_o | output | 1 | Keyboard-reset pulse on expiry |
| pgdrop_o | output | 1 | Power-good-drop pulse on expiry |
| irq_o | output | IRQ_LINES | Routed expiry interrupt, one line per route value |

## Verification
Two collisions matter most: a count restart landing on a unit tick, and an expiry landing on a control write that clears the status. The bench times a game-port or infrared pulse so that its delayed restart falls on a tick cycle. It also writes a count byte with the tick high, and writes control 0x00 in the exact cycle where the count goes from one to zero. A behavioural reference model, updated on every clock, decides the outcome each time: the count must hold the programmed value and expire only after the full number of further ticks, and the status must stay set. The model is compared with the pulse and interrupt outputs on every cycle and with register reads at chosen points.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int CNT_W = 16;

    localparam logic [7:0] IDX_DEVSEL = 8'h07;
    localparam logic [7:0] IDX_CTRL   = 8'h71;
    localparam logic [7:0] IDX_CFG    = 8'h72;
    localparam logic [7:0] IDX_CNT_LO = 8'h73;
    localparam logic [7:0] IDX_CNT_HI = 8'h74;

    // config byte: [7] unit is seconds, [6] keyboard reset, [5] spare,
    // [4] power-good drop, [3:0] interrupt route
    typedef struct packed {
        logic       unit_sec;
        logic       kb_en;
        logic       spare;
        logic       pg_en;
        logic [3:0] route;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DEVSEL,
        SEL_CTRL,
        SEL_CFG,
        SEL_LO,
        SEL_HI
    } reg_sel_e;

    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] value;
    } load_t;

    function automatic reg_sel_e decode_idx(input logic [7:0] idx, input logic dev_ok);
        reg_sel_e s;
        s = SEL_NONE;
        if (idx == IDX_DEVSEL) begin
            s = SEL_DEVSEL;
        end else if (dev_ok) begin
            case (idx)
                IDX_CTRL:   s = SEL_CTRL;
                IDX_CFG:    s = SEL_CFG;
                IDX_CNT_LO: s = SEL_LO;
                IDX_CNT_HI: s = SEL_HI;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] ctrl_byte(input logic ir_en, input logic gp_en,
                                             input logic status);
        return {ir_en, 2'b00, gp_en, 3'b000, status};
    endfunction

endpackage

// File: rtl/swd_regs.sv
module swd_regs
    import swd_pkg::*;
#(
    parameter logic [7:0] GPIO_LDN  = 8'h07,
    parameter int         IRQ_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           cfg_idx,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic                 expire,
    output cfg_t                 cfg,
    output logic                 ir_en,
    output logic                 gp_en,
    output logic [CNT_W-1:0]     prog,
    output load_t                ld,
    output logic                 status,
    output logic [IRQ_LINES-1:0] irq_o
);

    logic [7:0]       devsel_q;
    cfg_t             cfg_q;
    logic             ir_en_q, gp_en_q, status_q;
    logic [CNT_W-1:0] prog_q;
    reg_sel_e         sel;
    logic             wr_ctrl, wr_cfg, wr_dev;
    logic             clear_req;

    always_comb begin
        sel       = decode_idx(cfg_idx, devsel_q == GPIO_LDN);
        wr_dev    = cfg_wr && (sel == SEL_DEVSEL);
        wr_ctrl   = cfg_wr && (sel == SEL_CTRL);
        wr_cfg    = cfg_wr && (sel == SEL_CFG);
        clear_req = wr_ctrl && !cfg_wdata[0];
        ld.load   = cfg_wr && ((sel == SEL_LO) || (sel == SEL_HI));
        if (sel == SEL_LO) begin
            ld.value = {prog_q[CNT_W-1:8], cfg_wdata};
        end else begin
            ld.value = {cfg_wdata, prog_q[7:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            devsel_q <= '0;
            cfg_q    <= '0;
            ir_en_q  <= 1'b0;
            gp_en_q  <= 1'b0;
            prog_q   <= '0;
            status_q <= 1'b0;
        end else begin
            if (wr_dev) devsel_q <= cfg_wdata;
            if (wr_cfg) cfg_q <= cfg_t'(cfg_wdata);
            if (wr_ctrl) begin
                ir_en_q <= cfg_wdata[7];
                gp_en_q <= cfg_wdata[4];
            end
            if (ld.load) prog_q <= ld.value;
            if (expire) begin
                status_q <= 1'b1;
            end else if (clear_req) begin
                status_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_DEVSEL: cfg_rdata = devsel_q;
            SEL_CTRL:   cfg_rdata = ctrl_byte(ir_en_q, gp_en_q, status_q);
            SEL_CFG:    cfg_rdata = cfg_q;
            SEL_LO:     cfg_rdata = prog_q[7:0];
            SEL_HI:     cfg_rdata = prog_q[CNT_W-1:8];
            default:    cfg_rdata = 8'h00;
        endcase
    end

    assign irq_o[0] = 1'b0;
    generate
        for (genvar i = 1; i < IRQ_LINES; i++) begin : g_irq
            assign irq_o[i] = status_q && (cfg_q.route == 4'(i));
        end
    endgenerate

    assign cfg    = cfg_q;
    assign ir_en  = ir_en_q;
    assign gp_en  = gp_en_q;
    assign prog   = prog_q;
    assign status = status_q;

    // R6: only a clearing control write can drop the status
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        status_q && !clear_req |=> status_q);

    // R10: at most one interrupt line at a time
    p_irq_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_o));

endmodule

// File: rtl/swd_timebase.sv
module swd_timebase #(
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_sec,
    input  logic unit_sec,
    input  logic clr,
    output logic unit_tick
);

    localparam int PRE_W = $clog2(SEC_PER_MIN);

    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap      = (pre_q == PRE_W'(SEC_PER_MIN - 1));
    assign unit_tick = tick_sec && (unit_sec || wrap);

    always_ff @(posedge clk) begin
        if (rst || clr || unit_sec) begin
            pre_q <= '0;
        end else if (tick_sec) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

    // R5: the prescaler never passes its wrap value
    p_pre_range_r5: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PRE_W'(SEC_PER_MIN - 1));

endmodule

// File: rtl/swd_counter.sv
module swd_counter
    import swd_pkg::*;
#(
    parameter int RELOAD_LAT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unit_tick,
    input  load_t            ld,
    input  logic [CNT_W-1:0] prog,
    input  logic             ir_act,
    input  logic             gp_act,
    input  logic             ir_en,
    input  logic             gp_en,
    output logic             restart,
    output logic             expire
);

    localparam int DLY_W = $clog2(RELOAD_LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q;
    logic             done_q;
    logic             event_in, reload_now, running;

    always_comb begin
        event_in   = (ir_act && ir_en) || (gp_act && gp_en);
        reload_now = (dly_q == DLY_W'(1));
        restart    = ld.load || reload_now;
        running    = (prog != '0) && !done_q;
        expire     = unit_tick && running && (cnt_q == CNT_W'(1)) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dly_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (event_in) begin
                dly_q <= DLY_W'(RELOAD_LAT);
            end else if (dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end

            if (ld.load) begin
                cnt_q <= ld.value;
            end else if (reload_now) begin
                cnt_q <= prog;
            end else if (unit_tick && running) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (restart) begin
                done_q <= 1'b0;
            end else if (expire) begin
                done_q <= 1'b1;
            end
        end
    end

    // R5: a unit tick with no restart takes exactly one off a running count
    p_dec_one_r5: assert property (@(posedge clk) disable iff (rst)
        running && unit_tick && !restart |=> cnt_q == $past(cnt_q) - 1'b1);

    // R9: without a tick or a restart the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !unit_tick && !restart |=> $stable(cnt_q));

endmodule

// File: rtl/swd_pulse.sv
module swd_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);

    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(PULSE_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);

    // R7: a pulse starts only at full length
    p_pulse_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> left_q == PW'(PULSE_CYC));

endmodule

// File: rtl/swd_watchdog.sv
module swd_watchdog
    import swd_pkg::*;
#(
    parameter logic [7:0] GPIO_LDN    = 8'h07,
    parameter int         IRQ_LINES   = 16,
    parameter int         SEC_PER_MIN = 60,
    parameter int         RELOAD_LAT  = 8,
    parameter int         PULSE_CYC   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           cfg_idx,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic                 tick_sec,
    input  logic                 ir_act,
    input  logic                 gp_act,
    output logic                 kbrst_o,
    output logic                 pgdrop_o,
    output logic [IRQ_LINES-1:0] irq_o
);

    localparam int NUM_OUT = 2;

    cfg_t             cfg;
    logic             ir_en, gp_en, status;
    logic [CNT_W-1:0] prog;
    load_t            ld;
    logic             unit_tick, restart, expire;
    logic [NUM_OUT-1:0] fire, pulses;

    swd_regs #(.GPIO_LDN(GPIO_LDN), .IRQ_LINES(IRQ_LINES)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_idx(cfg_idx), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .expire(expire),
        .cfg(cfg), .ir_en(ir_en), .gp_en(gp_en), .prog(prog),
        .ld(ld), .status(status), .irq_o(irq_o)
    );

    swd_timebase #(.SEC_PER_MIN(SEC_PER_MIN)) u_tb (
        .clk(clk), .rst(rst), .tick_sec(tick_sec),
        .unit_sec(cfg.unit_sec), .clr(restart), .unit_tick(unit_tick)
    );

    swd_counter #(.RELOAD_LAT(RELOAD_LAT)) u_cnt (
        .clk(clk), .rst(rst), .unit_tick(unit_tick), .ld(ld), .prog(prog),
        .ir_act(ir_act), .gp_act(gp_act), .ir_en(ir_en), .gp_en(gp_en),
        .restart(restart), .expire(expire)
    );

    assign fire = {expire && cfg.pg_en, expire && cfg.kb_en};

    generate
        for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
            swd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
                .clk(clk), .rst(rst), .fire(fire[k]), .pulse(pulses[k])
            );
        end
    endgenerate

    assign kbrst_o  = pulses[0];
    assign pgdrop_o = pulses[1];

    // R7: a keyboard-reset pulse only begins together with a set status
    p_kbrst_status_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(kbrst_o) |-> status);

endmodule

// File: tb/test_swd_watchdog.sv
module test_swd_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int LAT   = 8;
    localparam int PLEN  = 4;
    localparam int SPM   = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_idx = 8'h00;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        tick_sec = 1'b0;
    logic        ir_act = 1'b0;
    logic        gp_act = 1'b0;
    logic        kbrst_o, pgdrop_o;
    logic [15:0] irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swd_watchdog i_swd_watchdog (
        .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_sec(tick_sec),
        .ir_act(ir_act), .gp_act(gp_act), .kbrst_o(kbrst_o),
        .pgdrop_o(pgdrop_o), .irq_o(irq_o)
    );

    // reference model state
    int m_dev, m_cfg, m_ir, m_gp, m_prog, m_cnt, m_done, m_stat, m_pre, m_dly, m_kb, m_pg;

    function automatic int m_read(input int idx);
        bool_ok: begin end
        if (idx == 8'h07) return m_dev;
        if (m_dev != 7) return 0;
        case (idx)
            8'h71: return (m_ir << 7) | (m_gp << 4) | m_stat;
            8'h72: return m_cfg;
            8'h73: return m_prog & 255;
            8'h74: return (m_prog >> 8) & 255;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dev = 0; m_cfg = 0; m_ir = 0; m_gp = 0; m_prog = 0; m_cnt = 0;
            m_done = 0; m_stat = 0; m_pre = 0; m_dly = 0; m_kb = 0; m_pg = 0;
        end else begin
            int idx, d, newprog, unit_s, utick, load, rel, rstrt, run, exp_now, ev;
            idx = cfg_idx; d = cfg_wdata;
            load = 0; newprog = m_prog;
            if (cfg_wr && m_dev == 7 && idx == 8'h73) begin load = 1; newprog = (m_prog & 16'hFF00) | d; end
            if (cfg_wr && m_dev == 7 && idx == 8'h74) begin load = 1; newprog = (m_prog & 255) | (d << 8); end
            rel     = (m_dly == 1);
            rstrt   = load || rel;
            ev      = (ir_act && m_ir) || (gp_act && m_gp);
            unit_s  = (m_cfg >> 7) & 1;
            utick   = tick_sec && (unit_s || m_pre == SPM - 1);
            run     = (m_prog != 0) && !m_done;
            exp_now = utick && run && (m_cnt == 1) && !rstrt;
            // prescaler
            if (rstrt || unit_s) m_pre = 0;
            else if (tick_sec) m_pre = (m_pre == SPM - 1) ? 0 : m_pre + 1;
            // count
            if (load) m_cnt = newprog;
            else if (rel) m_cnt = m_prog;
            else if (utick && run) m_cnt = m_cnt - 1;
            if (rstrt) m_done = 0; else if (exp_now) m_done = 1;
            if (ev) m_dly = LAT; else if (m_dly != 0) m_dly = m_dly - 1;
            // pulses use config before this edge's write
            if (exp_now && ((m_cfg >> 6) & 1)) m_kb = PLEN; else if (m_kb != 0) m_kb = m_kb - 1;
            if (exp_now && ((m_cfg >> 4) & 1)) m_pg = PLEN; else if (m_pg != 0) m_pg = m_pg - 1;
            if (exp_now) m_stat = 1;
            else if (cfg_wr && m_dev == 7 && idx == 8'h71 && !(d & 1)) m_stat = 0;
            // register writes
            if (cfg_wr && idx == 8'h07) m_dev = d;
            if (cfg_wr && m_dev == 7 && idx == 8'h72 && !(idx == 8'h07)) m_cfg = d;
            if (cfg_wr && m_dev == 7 && idx == 8'h71) begin m_ir = (d >> 7) & 1; m_gp = (d >> 4) & 1; end
            m_prog = newprog;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison of the registered outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_irq;
            exp_irq = 0;
            if (m_stat && (m_cfg & 15) != 0) exp_irq = 1 << (m_cfg & 15);
            check("R7 kbrst_o", kbrst_o, m_kb != 0);
            check("R7 pgdrop_o", pgdrop_o, m_pg != 0);
            check("R10 irq_o", irq_o, exp_irq);
        end
    end

    task automatic step(input logic wr, input logic [7:0] idx, input logic [7:0] d,
                        input logic t, input logic ir, input logic gp);
        cfg_wr = wr; cfg_idx = idx; cfg_wdata = d;
        tick_sec = t; ir_act = ir; gp_act = gp;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        step(1'b1, idx, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    // read compared with the model and with an expected value from the requirement
    task automatic rd(input string tag, input logic [7:0] idx, input int exp);
        cfg_wr = 1'b0; cfg_idx = idx; tick_sec = 1'b0; ir_act = 1'b0; gp_act = 1'b0;
        #1;
        check(tag, cfg_rdata, exp);
        check({tag, " model"}, cfg_rdata, m_read(idx));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 devsel", 8'h07, 8'h00);
        check("R1 kbrst_o", kbrst_o, 0);
        check("R1 irq_o", irq_o, 0);
        // R2 writes ignored while another device is selected
        wr(8'h72, 8'hAA);
        wr(8'h73, 8'h33);
        rd("R2 hidden read", 8'h72, 8'h00);
        wr(8'h07, 8'h07);
        rd("R2 cfg untouched", 8'h72, 8'h00);
        rd("R1 ctrl", 8'h71, 8'h00);
        rd("R1 count lo", 8'h73, 8'h00);
        rd("R2 unknown idx", 8'h75, 8'h00);
        // R4 zero count: no expiry
        wr(8'h72, 8'h80);
        ticks(20);
        rd("R4 stopped status", 8'h71, 8'h00);
        // R3/R5 seconds mode, both outputs, route 5
        wr(8'h72, 8'hD5);
        wr(8'h74, 8'h00);
        wr(8'h73, 8'h05);
        rd("R3 count lo", 8'h73, 8'h05);
        ticks(4);
        rd("R5 not yet", 8'h71, 8'h00);
        ticks(1);
        check("R10 irq line 5", irq_o, 16'h0020);
        rd("R6 status set", 8'h71, 8'h01);
        ticks(20);
        check("R7 no refire", kbrst_o, 0);
        wr(8'h71, 8'h00);
        rd("R6 status cleared", 8'h71, 8'h00);
        // R5 minute mode, count 2
        wr(8'h72, 8'h40);
        wr(8'h73, 8'h02);
        ticks(119);
        rd("R5 minute not yet", 8'h71, 8'h00);
        ticks(1);
        rd("R5 minute expiry", 8'h71, 8'h01);
        wr(8'h71, 8'h00);
        // R8 infrared restart, game port disabled
        wr(8'h72, 8'h93);
        wr(8'h71, 8'h80);
        wr(8'h73, 8'h0A);
        ticks(5);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        idle(LAT);
        ticks(9);
        rd("R8 restarted no expiry", 8'h71, 8'h80);
        ticks(1);
        rd("R8 expiry after restart", 8'h71, 8'h81);
        wr(8'h71, 8'h00);
        wr(8'h73, 8'h06);
        ticks(3);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        ticks(3);
        rd("R8 disabled gp ignored", 8'h71, 8'h01);
        // R9 delayed restart lands on a tick
        wr(8'h71, 8'h10);
        wr(8'h73, 8'h05);
        ticks(2);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        idle(LAT - 1);
        ticks(1);
        ticks(4);
        rd("R9 restart beat tick", 8'h71, 8'h10);
        ticks(1);
        rd("R9 expiry after full count", 8'h71, 8'h11);
        // R9 count write with tick high
        step(1'b1, 8'h73, 8'h03, 1'b1, 1'b0, 1'b0);
        rd("R9 load value", 8'h73, 8'h03);
        ticks(2);
        // R6 expiry and clearing write in one cycle
        step(1'b1, 8'h71, 8'h00, 1'b1, 1'b0, 1'b0);
        rd("R6 expiry wins over clear", 8'h71, 8'h01);
        idle(8);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired R1 actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule